// File: doc/BRIEF.md
# Asynchronous Read Handshake Responder

This block is the memory-side agent of a read transaction on an unclocked, interlocked bus. An I/O device (the requester) shares one set of data lines with it. The requester places an address on those lines and raises a request. The responder captures that address and acknowledges it. It then waits for the request to be withdrawn and fetches the addressed word from a small internal memory. It returns the word on the same lines with a data-ready strobe, and it drops the strobe once the requester acknowledges the data.

The responder has its own clock. The two control lines from the requester, the request and the requester's acknowledge, have no timing relation to that clock. Each one passes through a two-stage synchronizer before the sequencer uses it. Every step of the sequencer waits for an observed level change on the other party's line, so the transaction holds together for any requester speed. The shared lines are modelled as an input, an output and an output enable. The responder enables its driver only while data-ready is high, so it never drives the lines at the same time as the requester.

Top module: `async_read_responder`

## Requirements
- R1: While reset is held and just after it is released, `ack_o`, `drdy_o` and `bus_oe_o` are low and `bus_o` is zero.
- R2: When `rd_req_i` rises in an idle responder, `ack_o` goes high exactly three clock edges later: two synchronizer stages and one sequencer register. The address is captured from `bus_i[AW-1:0]` on the edge where the request is seen.
- R3: `ack_o` stays high while the synchronized request is high. It falls exactly three clock edges after `rd_req_i` falls.
- R4: `drdy_o` rises exactly LAT clock edges after `ack_o` falls (LAT is a parameter from 1 to 8). The word shown is `(addr * 37 + 90) mod 2^DW` for the captured address, and it holds steady while `drdy_o` is high.
- R5: `bus_oe_o` is high in exactly the cycles where `drdy_o` is high, and never together with `ack_o`. While `bus_oe_o` is low, `bus_o` is zero.
- R6: After `host_ack_i` rises, `drdy_o` and `bus_oe_o` stay high for two more edges and fall on the third.
- R7: A new request is not accepted while the requester's acknowledge is still high. If `rd_req_i` is already high when `host_ack_i` falls, `ack_o` rises exactly four edges after that fall.
- R8: Values on `bus_i` after the address has been captured have no effect on the word returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Active-low reset |
| rd_req_i | input | 1 | Read request from the requester (asynchronous) |
| host_ack_i | input | 1 | Requester's acknowledge of the returned data (asynchronous) |
| bus_i | input | DW | Value seen on the shared data lines |
| bus_o | output | DW | Value the responder drives onto the shared lines |
| bus_oe_o | output | 1 | Output enable of the responder's driver |
| ack_o | output | 1 | Responder's acknowledge of the address |
| drdy_o | output | 1 | Read data is valid on the shared lines |

## Verification
Each output change is due a fixed number of edges after its stimulus. The acknowledge moves three edges after a request edge. Data-ready rises LAT edges after the acknowledge falls. It falls three edges after the requester's acknowledge rises. A request held over the end of a transaction is accepted four edges after the requester's acknowledge falls. The bench changes its inputs on falling clock edges and counts falling edges from each stimulus. It checks that the output has not yet moved on the edge before it is due, and that it has moved on the edge where it is due.

// File: rtl/async_read_responder.sv
module async_read_responder #(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req_i,
  input  logic          host_ack_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          ack_o,
  output logic          drdy_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_FETCH, S_DRDY, S_DONE} st_t;

  st_t             st;
  logic [1:0]      req_sync, ack_sync;
  logic            req_s, hack_s;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   data_q;
  logic [DW-1:0]   mem [DEPTH];

  assign req_s  = req_sync[1];
  assign hack_s = ack_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_sync <= '0;
    end else begin
      req_sync <= {req_sync[0], rd_req_i};
      ack_sync <= {ack_sync[0], host_ack_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i * 37 + 90);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE:  if (req_s) begin
                   addr_q <= bus_i[AW-1:0];
                   st     <= S_ACK;
                 end
        S_ACK:   if (!req_s) begin
                   cnt <= '0;
                   st  <= S_FETCH;
                 end
        S_FETCH: if (cnt == CW'(LAT - 1)) begin
                   data_q <= mem[addr_q];
                   st     <= S_DRDY;
                 end else begin
                   cnt <= cnt + 1'b1;
                 end
        S_DRDY:  if (hack_s) st <= S_DONE;
        S_DONE:  if (!hack_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack_o    = (st == S_ACK);
  assign drdy_o   = (st == S_DRDY);
  assign bus_oe_o = drdy_o;
  assign bus_o    = bus_oe_o ? data_q : '0;

  // R3: the acknowledge is held until the request is seen low
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_s) |=> ack_o);

  // R5: the driver is never enabled together with the address acknowledge
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !ack_o);

  // R4: the returned word holds steady while data-ready stays high
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_o && $past(drdy_o)) |-> $stable(bus_o));

  // R6: data-ready is held until the requester's acknowledge is seen
  p_drdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_o && !hack_s) |=> drdy_o);

  // R7: no address acknowledge while the requester's acknowledge is still seen high
  p_no_early_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> !hack_s);

  // R5: the lines carry zero whenever the driver is off
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (bus_o == '0));
endmodule

// File: tb/async_read_responder_tb.sv
module async_read_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req_i = 1'b0;
  logic          host_ack_i = 1'b0;
  logic [DW-1:0] bus_i = '0;
  logic [DW-1:0] bus_o;
  logic          bus_oe_o, ack_o, drdy_o;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_read_responder #(.DW(DW), .AW(AW), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .host_ack_i(host_ack_i),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .ack_o(ack_o), .drdy_o(drdy_o)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return DW'(a * 37 + 90);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // address phase: raise request, check ack timing, release lines
  task automatic addr_phase(input int a);
    @(negedge clk);
    rd_req_i = 1'b1; bus_i = DW'(a);
    negs(2); chk("R2 ack not yet", ack_o, 0);
    negs(1); chk("R2 ack raised", ack_o, 1);
    rd_req_i = 1'b0; bus_i = ~DW'(a);
    negs(2); chk("R3 ack held", ack_o, 1);
    negs(1); chk("R3 ack dropped", ack_o, 0);
  endtask

  task automatic data_phase(input int a);
    if (LAT > 1) begin
      negs(LAT - 1); chk("R4 drdy not yet", drdy_o, 0);
    end
    bus_i = 8'hC3;
    negs(1);
    chk("R4 drdy raised", drdy_o, 1);
    chk("R5 oe with drdy", bus_oe_o, 1);
    chk("R4 word", bus_o, word_of(a));
    chk("R5 no ack with oe", ack_o, 0);
    host_ack_i = 1'b1;
    negs(2);
    chk("R6 drdy held", drdy_o, 1);
    chk("R4 word stable", bus_o, word_of(a));
    negs(1);
    chk("R6 drdy dropped", drdy_o, 0);
    chk("R5 oe dropped", bus_oe_o, 0);
    chk("R5 bus zero", bus_o, 0);
  endtask

  task automatic test_reset;
    negs(2);
    chk("R1 ack in reset", ack_o, 0);
    chk("R1 drdy in reset", drdy_o, 0);
    rst_n = 1'b1;
    negs(1);
    chk("R1 oe after reset", bus_oe_o, 0);
    chk("R1 bus after reset", bus_o, 0);
  endtask

  task automatic test_read(input int a);
    addr_phase(a);
    data_phase(a);
    host_ack_i = 1'b0;
    negs(3);
    chk("R7 idle ack", ack_o, 0);
  endtask

  // R8: lines wiggle after capture, word still follows the captured address
  task automatic test_bus_noise(input int a);
    addr_phase(a);
    for (int i = 0; i < LAT - 1; i++) begin
      @(negedge clk); bus_i = DW'(i * 51 + 7);
    end
    negs(1);
    chk("R8 word unaffected", bus_o, word_of(a));
    host_ack_i = 1'b1; negs(3);
    host_ack_i = 1'b0; negs(3);
  endtask

  // R7: request raised early is held off until requester ack falls
  task automatic test_early_req(input int a, input int b);
    addr_phase(a);
    data_phase(a);
    rd_req_i = 1'b1; bus_i = DW'(b);
    negs(4);
    chk("R7 held off", ack_o, 0);
    host_ack_i = 1'b0;
    negs(3); chk("R7 not yet", ack_o, 0);
    negs(1); chk("R7 accepted", ack_o, 1);
    rd_req_i = 1'b0; bus_i = '0;
    negs(2); chk("R3 ack held", ack_o, 1);
    negs(1); chk("R3 ack dropped", ack_o, 0);
    data_phase(b);
    host_ack_i = 1'b0;
    negs(3);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_read(0);
        test_read(5);
        test_read(15);
        test_bus_noise(9);
        test_early_req(3, 12);
        test_read(10);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule